// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital controller of a dual-slope integrating converter. It runs a repeating measurement made of four phases, always in the same order: auto-zero, signal integrate, reference de-integrate and zero-integrate. Each phase is shown on one bit of a one-hot output that steers the external analog switches. The block samples one comparator bit on every clock. At the end of signal integrate, that comparator value fixes the input polarity, and the polarity selects which reference is switched in during de-integrate.

De-integrate ends on the first clock on which the comparator differs from the captured polarity. The number of de-integrate clocks before that crossing is latched as a signed two's-complement reading. If no crossing arrives before the count limit, the reading is flagged as overrange. An overrange stretches the following zero-integrate phase, and auto-zero takes up whatever time is left so that a running cycle always has the same length. When the run input is low at the end of auto-zero, the sequencer stays in auto-zero and keeps the last reading until the run input returns high.

Top module: `dsadc_sequencer`

## Requirements
- R1: The phase output is one-hot and the phases follow auto-zero, integrate, de-integrate, zero-integrate, then auto-zero again. The bits are bit 0 auto-zero, bit 1 integrate, bit 2 de-integrate and bit 3 zero-integrate.
- R2: Signal integrate lasts exactly INT_LEN clocks.
- R3: The polarity is the comparator value sampled on the last integrate clock. During de-integrate, `ref_neg_o` is high when that polarity is 1 and `ref_pos_o` is high when it is 0. Outside de-integrate both are low.
- R4: De-integrate ends on the first clock whose sampled comparator differs from the polarity. The reading magnitude is the zero-based index of that clock. The reading is positive for polarity 1 and negated in two's complement for polarity 0.
- R5: If DEINT_MAX de-integrate clocks pass without a crossing, `ovr_o` becomes 1 and the reading magnitude is DEINT_MAX. A crossing on the last allowed clock is a normal reading.
- R6: Zero-integrate lasts ZI_NORM clocks after a normal reading and ZI_OVR clocks after an overrange.
- R7: While running, auto-zero lasts CYCLE_LEN minus the clocks used by the other three phases, so every cycle totals CYCLE_LEN. Auto-zero is never shorter than AZ_MIN_NORM after a normal reading or AZ_MIN_OVR after an overrange. The first auto-zero after reset lasts AZ_MIN_NORM.
- R8: The run input is sampled on the last auto-zero clock. If it is low, the block remains in auto-zero with the reading unchanged. Integrate starts on the clock after the run input returns high.
- R9: The reading, `pos_o` and `ovr_o` change only at the end of de-integrate. `done_o` pulses for exactly one clock, on the first zero-integrate clock, together with the new values.
- R10: During reset the phase is auto-zero, and the reading, `ovr_o`, `done_o` and both reference selects are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Conversion clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | High: convert continuously; low: hold in auto-zero |
| comp_i | input | 1 | Comparator output, 1 when the integrator is above zero |
| phase_o | output | 4 | One-hot phase: bit 0 AZ, bit 1 INT, bit 2 DE, bit 3 ZI |
| ref_pos_o | output | 1 | Apply the positive reference (de-integrate, polarity 0) |
| ref_neg_o | output | 1 | Apply the negative reference (de-integrate, polarity 1) |
| result_o | output | RES_W | Signed reading, two's complement |
| pos_o | output | 1 | Polarity of the held reading |
| ovr_o | output | 1 | Held reading is overrange |
| done_o | output | 1 | One-clock pulse when a new reading is latched |

## Verification
Phase changes take effect on the clock edge that follows the deciding clock. The new reading and `done_o` therefore appear together with the first zero-integrate clock, one edge after the crossing is sampled. The bench drives the comparator and the run input on falling edges and samples on falling edges. It counts the falling edges spent in each phase, so every phase length and the whole-cycle total are measured in clocks rather than in absolute time. A comparator flip is applied on the falling edge whose de-integrate index equals the wanted count, so the rising edge that follows samples it. The reading is checked on the first zero-integrate falling edge, and the absence of the pulse is checked on the next one.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;
    typedef enum logic [1:0] {
        PH_AZ  = 2'd0,
        PH_INT = 2'd1,
        PH_DE  = 2'd2,
        PH_ZI  = 2'd3
    } phase_e;

    localparam int NUM_PHASES = 4;
endpackage

// File: rtl/dsadc_phase_ctrl.sv
module dsadc_phase_ctrl
    import dsadc_pkg::*;
#(
    parameter int INT_LEN     = 10000,
    parameter int DEINT_MAX   = 20001,
    parameter int ZI_NORM     = 200,
    parameter int ZI_OVR      = 6200,
    parameter int AZ_MIN_NORM = 9800,
    parameter int AZ_MIN_OVR  = 3800,
    parameter int CYCLE_LEN   = 40002,
    parameter int CNT_W       = 16,
    parameter int MAG_W       = 15
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             comp_i,
    input  logic             ovr_last_i,
    output phase_e           phase_o,
    output logic             pol_o,
    output logic             de_end_o,
    output logic             de_ovr_o,
    output logic [MAG_W-1:0] de_mag_o
);
    localparam logic [CNT_W-1:0] INT_LAST  = CNT_W'(INT_LEN - 1);
    localparam logic [CNT_W-1:0] DE_LAST   = CNT_W'(DEINT_MAX - 1);
    localparam logic [CNT_W-1:0] ZIN_LAST  = CNT_W'(ZI_NORM - 1);
    localparam logic [CNT_W-1:0] ZIO_LAST  = CNT_W'(ZI_OVR - 1);
    localparam logic [CNT_W-1:0] AZ_RESET  = CNT_W'(AZ_MIN_NORM);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] az_tgt;
        logic             pol;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  crossed;
    int    rem;
    int    floor_v;

    always_comb begin
        st_d     = st_q;
        de_end_o = 1'b0;
        de_ovr_o = 1'b0;
        de_mag_o = '0;
        rem      = 0;
        floor_v  = 0;
        crossed  = (comp_i != st_q.pol);
        unique case (st_q.ph)
            PH_AZ: begin
                if (st_q.cnt >= st_q.az_tgt - 1'b1) begin
                    if (run_i) begin
                        st_d.ph  = PH_INT;
                        st_d.cnt = '0;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_INT: begin
                if (st_q.cnt == INT_LAST) begin
                    st_d.ph  = PH_DE;
                    st_d.cnt = '0;
                    st_d.pol = comp_i;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_DE: begin
                if (crossed || st_q.cnt == DE_LAST) begin
                    de_end_o = 1'b1;
                    de_ovr_o = !crossed;
                    de_mag_o = MAG_W'(st_q.cnt) + MAG_W'(!crossed);
                    rem      = CYCLE_LEN - INT_LEN - 1 - int'(st_q.cnt)
                             - (crossed ? ZI_NORM : ZI_OVR);
                    floor_v  = crossed ? AZ_MIN_NORM : AZ_MIN_OVR;
                    st_d.az_tgt = CNT_W'((rem < floor_v) ? floor_v : rem);
                    st_d.ph  = PH_ZI;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_ZI: begin
                if (st_q.cnt == (ovr_last_i ? ZIO_LAST : ZIN_LAST)) begin
                    st_d.ph  = PH_AZ;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d = st_q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.ph     <= PH_AZ;
            st_q.cnt    <= '0;
            st_q.az_tgt <= AZ_RESET;
            st_q.pol    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o = st_q.ph;
    assign pol_o   = st_q.pol;
endmodule

// File: rtl/dsadc_result_reg.sv
module dsadc_result_reg #(
    parameter int MAG_W = 15,
    parameter int RES_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             de_end_i,
    input  logic             de_ovr_i,
    input  logic             pol_i,
    input  logic [MAG_W-1:0] de_mag_i,
    output logic [RES_W-1:0] result_o,
    output logic             pos_o,
    output logic             ovr_o,
    output logic             done_o
);
    typedef struct packed {
        logic [RES_W-1:0] res;
        logic             pos;
        logic             ovr;
        logic             done;
    } hold_t;

    hold_t            rg_d, rg_q;
    logic [RES_W-1:0] mag_ext;

    always_comb begin
        rg_d      = rg_q;
        mag_ext   = {1'b0, de_mag_i};
        rg_d.done = de_end_i;
        if (de_end_i) begin
            rg_d.res = pol_i ? mag_ext : (~mag_ext + 1'b1);
            rg_d.pos = pol_i;
            rg_d.ovr = de_ovr_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign result_o = rg_q.res;
    assign pos_o    = rg_q.pos;
    assign ovr_o    = rg_q.ovr;
    assign done_o   = rg_q.done;
endmodule

// File: rtl/dsadc_switch_decode.sv
module dsadc_switch_decode
    import dsadc_pkg::*;
(
    input  phase_e                phase_i,
    input  logic                  pol_i,
    output logic [NUM_PHASES-1:0] phase_oh_o,
    output logic                  ref_pos_o,
    output logic                  ref_neg_o
);
    for (genvar g = 0; g < NUM_PHASES; g++) begin : g_oh
        assign phase_oh_o[g] = (phase_i == phase_e'(g));
    end

    assign ref_neg_o = (phase_i == PH_DE) &&  pol_i;
    assign ref_pos_o = (phase_i == PH_DE) && !pol_i;
endmodule

// File: rtl/dsadc_sequencer.sv
module dsadc_sequencer
    import dsadc_pkg::*;
#(
    parameter int INT_LEN     = 10000,
    parameter int DEINT_MAX   = 20001,
    parameter int ZI_NORM     = 200,
    parameter int ZI_OVR      = 6200,
    parameter int AZ_MIN_NORM = 9800,
    parameter int AZ_MIN_OVR  = 3800,
    parameter int CYCLE_LEN   = 40002,
    localparam int MAG_W      = $clog2(DEINT_MAX + 1),
    localparam int RES_W      = MAG_W + 1
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  run_i,
    input  logic                  comp_i,
    output logic [NUM_PHASES-1:0] phase_o,
    output logic                  ref_pos_o,
    output logic                  ref_neg_o,
    output logic [RES_W-1:0]      result_o,
    output logic                  pos_o,
    output logic                  ovr_o,
    output logic                  done_o
);
    localparam int CNT_W = $clog2(CYCLE_LEN + 1);

    phase_e           phase;
    logic             pol;
    logic             de_end;
    logic             de_ovr;
    logic [MAG_W-1:0] de_mag;

    dsadc_phase_ctrl #(
        .INT_LEN    (INT_LEN),
        .DEINT_MAX  (DEINT_MAX),
        .ZI_NORM    (ZI_NORM),
        .ZI_OVR     (ZI_OVR),
        .AZ_MIN_NORM(AZ_MIN_NORM),
        .AZ_MIN_OVR (AZ_MIN_OVR),
        .CYCLE_LEN  (CYCLE_LEN),
        .CNT_W      (CNT_W),
        .MAG_W      (MAG_W)
    ) i_ctrl (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (run_i),
        .comp_i    (comp_i),
        .ovr_last_i(ovr_o),
        .phase_o   (phase),
        .pol_o     (pol),
        .de_end_o  (de_end),
        .de_ovr_o  (de_ovr),
        .de_mag_o  (de_mag)
    );

    dsadc_result_reg #(
        .MAG_W(MAG_W),
        .RES_W(RES_W)
    ) i_res (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .de_end_i(de_end),
        .de_ovr_i(de_ovr),
        .pol_i   (pol),
        .de_mag_i(de_mag),
        .result_o(result_o),
        .pos_o   (pos_o),
        .ovr_o   (ovr_o),
        .done_o  (done_o)
    );

    dsadc_switch_decode i_dec (
        .phase_i   (phase),
        .pol_i     (pol),
        .phase_oh_o(phase_o),
        .ref_pos_o (ref_pos_o),
        .ref_neg_o (ref_neg_o)
    );
endmodule

// File: rtl/dsadc_sequencer_chk.sv
module dsadc_sequencer_chk #(
    parameter int DEINT_MAX = 20001,
    parameter int RES_W     = 16
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             run_i,
    input logic [3:0]       phase_o,
    input logic             ref_pos_o,
    input logic             ref_neg_o,
    input logic [RES_W-1:0] result_o,
    input logic             pos_o,
    input logic             ovr_o,
    input logic             done_o
);
    localparam logic [RES_W-1:0] OVR_P = RES_W'(DEINT_MAX);
    localparam logic [RES_W-1:0] OVR_N = ~OVR_P + 1'b1;

    AST_PHASE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $countones(phase_o) == 1); // R1

    AST_ZI_AFTER_DE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(phase_o[3]) |-> $past(phase_o[2])); // R1

    AST_REF_IN_DE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        phase_o[2] |-> (ref_pos_o != ref_neg_o)); // R3

    AST_REF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !phase_o[2] |-> !(ref_pos_o || ref_neg_o)); // R3

    AST_OVR_MAGNITUDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o && ovr_o) |-> (result_o == OVR_P || result_o == OVR_N)); // R5

    AST_INT_NEEDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(phase_o[1]) |-> ($past(phase_o[0]) && $past(run_i))); // R8

    AST_HOLD_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_o[0] && !run_i) |=> phase_o[0]); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R9

    AST_DONE_AT_ZI: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (phase_o[3] && $past(phase_o[2]))); // R9

    AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> ($stable(result_o) && $stable(pos_o) && $stable(ovr_o))); // R9
endmodule

bind dsadc_sequencer dsadc_sequencer_chk #(
    .DEINT_MAX(DEINT_MAX),
    .RES_W    (RES_W)
) i_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run_i),
    .phase_o  (phase_o),
    .ref_pos_o(ref_pos_o),
    .ref_neg_o(ref_neg_o),
    .result_o (result_o),
    .pos_o    (pos_o),
    .ovr_o    (ovr_o),
    .done_o   (done_o)
);

// File: tb/test_dsadc_sequencer.sv
`timescale 1ns/1ps
module test_dsadc_sequencer;
    localparam int INT_LEN     = 100;
    localparam int DEINT_MAX   = 201;
    localparam int ZI_NORM     = 2;
    localparam int ZI_OVR      = 62;
    localparam int AZ_MIN_NORM = 98;
    localparam int AZ_MIN_OVR  = 38;
    localparam int CYCLE_LEN   = 402;
    localparam int RW          = $clog2(DEINT_MAX + 1) + 1;

    localparam logic [3:0] OH_AZ  = 4'b0001;
    localparam logic [3:0] OH_INT = 4'b0010;
    localparam logic [3:0] OH_DE  = 4'b0100;
    localparam logic [3:0] OH_ZI  = 4'b1000;

    localparam int NV = 7;
    // polarity, crossing index (>= DEINT_MAX means none), expected reading, expected overrange
    localparam bit VEC_P   [NV] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
    localparam int VEC_K   [NV] = '{50, 120, 0, 200, 999, 999, 77};
    localparam int VEC_RES [NV] = '{50, -120, 0, -200, 201, -201, 77};
    localparam bit VEC_OVR [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          run = 1'b1;
    logic          comp = 1'b0;
    logic [3:0]    phase;
    logic          ref_pos, ref_neg, pos, ovr, done;
    logic [RW-1:0] result;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #2.5 clk = ~clk;

    dsadc_sequencer #(
        .INT_LEN    (INT_LEN),
        .DEINT_MAX  (DEINT_MAX),
        .ZI_NORM    (ZI_NORM),
        .ZI_OVR     (ZI_OVR),
        .AZ_MIN_NORM(AZ_MIN_NORM),
        .AZ_MIN_OVR (AZ_MIN_OVR),
        .CYCLE_LEN  (CYCLE_LEN)
    ) i_dsadc_sequencer (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .run_i    (run),
        .comp_i   (comp),
        .phase_o  (phase),
        .ref_pos_o(ref_pos),
        .ref_neg_o(ref_neg),
        .result_o (result),
        .pos_o    (pos),
        .ovr_o    (ovr),
        .done_o   (done)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 phase", int'(phase), int'(OH_AZ));
        chk("R10 result", int'(result), 0);
        chk("R10 ovr/done", int'({ovr, done}), 0);
        chk("R10 refs", int'({ref_pos, ref_neg}), 0);
        rst_n = 1'b1;
        n = 0;
        while (phase == OH_AZ) begin n++; @(negedge clk); end
        chk("R7 first auto-zero", n, AZ_MIN_NORM);

        for (int v = 0; v < NV; v++) begin
            int n_int, n_de, n_zi, n_az, exp_de, exp_zi, exp_az;
            comp  = VEC_P[v];
            n_int = 0;
            chk("R1 integrate follows auto-zero", int'(phase), int'(OH_INT));
            while (phase == OH_INT) begin n_int++; @(negedge clk); end
            chk("R2 integrate length", n_int, INT_LEN);
            chk("R1 de-integrate follows integrate", int'(phase), int'(OH_DE));
            chk("R3 reference select", int'({ref_pos, ref_neg}),
                VEC_P[v] ? 1 : 2);
            n_de = 0;
            while (phase == OH_DE) begin
                if (n_de == VEC_K[v]) comp = ~VEC_P[v];
                if (done) chk("R9 no pulse in de-integrate", 1, 0);
                @(negedge clk);
                n_de++;
            end
            exp_de = (VEC_K[v] < DEINT_MAX) ? VEC_K[v] + 1 : DEINT_MAX;
            chk("R4 de-integrate length", n_de, exp_de);
            chk("R1 zero-integrate follows", int'(phase), int'(OH_ZI));
            chk("R9 done pulse", int'(done), 1);
            chk(VEC_OVR[v] ? "R5 overrange reading" : "R4 reading",
                int'($signed(result)), VEC_RES[v]);
            chk("R5 overrange flag", int'(ovr), int'(VEC_OVR[v]));
            chk("R4 polarity", int'(pos), int'(VEC_P[v]));
            n_zi = 0;
            while (phase == OH_ZI) begin
                n_zi++;
                if (n_zi == 2) chk("R9 single pulse", int'(done), 0);
                @(negedge clk);
            end
            exp_zi = VEC_OVR[v] ? ZI_OVR : ZI_NORM;
            chk("R6 zero-integrate length", n_zi, exp_zi);
            n_az = 0;
            while (phase == OH_AZ) begin n_az++; @(negedge clk); end
            exp_az = CYCLE_LEN - INT_LEN - exp_de - exp_zi;
            if (exp_az < (VEC_OVR[v] ? AZ_MIN_OVR : AZ_MIN_NORM))
                exp_az = VEC_OVR[v] ? AZ_MIN_OVR : AZ_MIN_NORM;
            chk("R7 auto-zero length", n_az, exp_az);
            chk("R7 cycle total", n_int + n_de + n_zi + n_az, CYCLE_LEN);
        end

        // R8 hold: run low during a conversion, it completes then stays in auto-zero
        begin
            int j;
            run  = 1'b0;
            comp = 1'b1;
            while (phase == OH_INT) @(negedge clk);
            j = 0;
            while (phase == OH_DE) begin
                if (j == 30) comp = 1'b0;
                @(negedge clk);
                j++;
            end
            chk("R8 reading before hold", int'($signed(result)), 30);
            while (phase == OH_ZI) @(negedge clk);
            for (int c = 0; c < 400; c++) begin
                if (phase != OH_AZ || done) chk("R8 held in auto-zero", int'(phase), int'(OH_AZ));
                @(negedge clk);
            end
            chk("R8 still auto-zero", int'(phase), int'(OH_AZ));
            chk("R8 reading held", int'($signed(result)), 30);
            run = 1'b1;
            @(negedge clk);
            chk("R8 restart after run high", int'(phase), int'(OH_INT));
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule